// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor with Branch-Target Table

This block is a small single-cycle processor that runs a program from its own instruction ROM. Every instruction is nine bits wide and names at most one operand, because register 0 acts as the accumulator. Register 0 is the implied source and destination of all arithmetic. Arithmetic that produces a carry, a borrow or a shifted-out bit writes that bit to register 1 in the same cycle. Jumps and branches do not use a PC-relative offset. Their operand field selects an entry in a 32-entry target table, and that entry holds the full destination address. Loads and stores reach a 32-word data memory indirectly, through an address held in a register.

The surrounding logic first writes the instruction ROM and the target table through two write ports. It then pulses `start`. The core steps through the program one instruction per clock until it executes the stop opcode. At that point it raises `done` and freezes. Two combinational read ports expose any register and any data-memory word, so the results can be inspected after the run.

Top module: `acc_core`

## Requirements
- R1: An instruction carries its opcode in bits [8:5] and its operand field in bits [4:0]. The opcodes are: 0 idle, 1 copy accumulator to register, 2 copy register to accumulator, 3 load immediate, 4 add, 5 subtract, 6 and, 7 or, 8 xor, 9 shift left, 10 load, 11 store, 12 branch if equal, 13 branch if not equal, 14 jump, 15 stop.
- R2: Add writes the low 8 bits of accumulator + R[f] to register 0 and the carry-out (0 or 1) to register 1 on the same clock edge.
- R3: Subtract writes accumulator − R[f] modulo 256 to register 0 and writes 1 to register 1 when the accumulator is smaller than R[f], otherwise 0. And, or and xor combine the accumulator with R[f] and leave register 1 unchanged. Shift left doubles the accumulator modulo 256 and writes its old bit 7 to register 1.
- R4: Opcode 1 writes the accumulator to R[f]. Opcode 2 copies R[f] into the accumulator. Opcode 3 loads the zero-extended 5-bit field into the accumulator.
- R5: Load sets the accumulator to mem[R[f] mod 32]. Store writes the accumulator to mem[R[f] mod 32]. Only the low five bits of the pointer register select the word.
- R6: While running, any instruction other than a taken branch, a jump or stop advances the PC by one. The PC wraps from the last ROM address to 0.
- R7: Branch if equal is taken when the accumulator equals R[f]. Branch if not equal is taken when they differ. A taken branch loads the PC with table[f]; a branch that is not taken advances by one.
- R8: Jump always loads the PC with table[f].
- R9: Stop raises `done` and holds the PC. While stopped, no register, memory word or PC changes until the next `start`.
- R10: Reset clears the PC, all registers, all memory words and `done`, and leaves the core idle. A `start` pulse sets the PC to 0, clears `done`, and execution begins on the following cycle.
- R11: The ROM and table write ports take effect on the rising edge. The register and memory read ports return the addressed entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run from address 0 |
| romWe | input | 1 | Instruction ROM write strobe |
| romAddr | input | IADDR_W | Instruction ROM write address |
| romData | input | 9 | Instruction word to store |
| tblWe | input | 1 | Target table write strobe |
| tblAddr | input | 5 | Target table entry to write |
| tblData | input | IADDR_W | Target address to store |
| dbgRegSel | input | 5 | Register selected for read-out |
| dbgMemSel | input | 5 | Memory word selected for read-out |
| pc | output | IADDR_W | Current program counter |
| done | output | 1 | High once stop has executed, until the next start |
| dbgRegVal | output | DATA_W | Contents of the selected register |
| dbgMemVal | output | DATA_W | Contents of the selected memory word |

## Verification
The bench runs three programs. The first drives the arithmetic through a carry-out and a carry-free add, a borrowing and a non-borrowing subtract, a shift with bit 7 set, and the three logic operations; this separates the carry and borrow paths into register 1 from the operations that must leave it alone. The second fills memory in a loop closed by a branch if not equal. It then reads memory through pointers, including one whose upper bits must be dropped, and takes or skips each branch kind and a jump, so a wrong comparison sense or a wrong table index sends the PC somewhere visibly different. The third program runs the PC off the end of the ROM to show the wrap to 0. Stop and restart are also exercised around every run.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;
  localparam int FLD_W = 5;
  localparam int INS_W = OPC_W + FLD_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_PUT   = 4'd1,
    OP_GET   = 4'd2,
    OP_LDI   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_SHL   = 4'd9,
    OP_LOAD  = 4'd10,
    OP_STORE = 4'd11,
    OP_BEQ   = 4'd12,
    OP_BNE   = 4'd13,
    OP_JMP   = 4'd14,
    OP_STOP  = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_IMM, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SHL
  } aluOp_e;

  typedef struct packed {
    logic   accWe;
    logic   accFromMem;
    aluOp_e aluOp;
    logic   ovWe;
    logic   regWe;
    logic   memWe;
    logic   pcStep;
    logic   pcLoad;
    logic   pcClear;
  } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opIn,
  input  logic [FLD_W-1:0]  immIn,
  output logic [DATA_W-1:0] res,
  output logic              ovBit
);
  logic [DATA_W:0] wide;
  logic [DATA_W-1:0] immExt;

  assign immExt = {{(DATA_W-FLD_W){1'b0}}, immIn};

  always_comb begin
    case (op)
      ALU_PASS: wide = {1'b0, opIn};
      ALU_IMM:  wide = {1'b0, immExt};
      ALU_ADD:  wide = {1'b0, accIn} + {1'b0, opIn};
      ALU_SUB:  wide = {1'b0, accIn} - {1'b0, opIn};
      ALU_AND:  wide = {1'b0, accIn & opIn};
      ALU_OR:   wide = {1'b0, accIn | opIn};
      ALU_XOR:  wide = {1'b0, accIn ^ opIn};
      ALU_SHL:  wide = {accIn, 1'b0};
      default:  wide = '0;
    endcase
  end

  assign res   = wide[DATA_W-1:0];
  assign ovBit = wide[DATA_W];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  opcode_e opcode,
  input  logic    accEqOp,
  output ctrl_t   ctl,
  output logic    done
);
  logic runQ, doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else if (start) begin
      runQ  <= 1'b1;
      doneQ <= 1'b0;
    end else if (runQ && opcode == OP_STOP) begin
      runQ  <= 1'b0;
      doneQ <= 1'b1;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.aluOp   = ALU_PASS;
    ctl.pcClear = start;
    if (runQ && !start) begin
      case (opcode)
        OP_PUT:   ctl.regWe = 1'b1;
        OP_GET:   ctl.accWe = 1'b1;
        OP_LDI:   begin ctl.accWe = 1'b1; ctl.aluOp = ALU_IMM; end
        OP_ADD:   begin ctl.accWe = 1'b1; ctl.ovWe = 1'b1; ctl.aluOp = ALU_ADD; end
        OP_SUB:   begin ctl.accWe = 1'b1; ctl.ovWe = 1'b1; ctl.aluOp = ALU_SUB; end
        OP_AND:   begin ctl.accWe = 1'b1; ctl.aluOp = ALU_AND; end
        OP_OR:    begin ctl.accWe = 1'b1; ctl.aluOp = ALU_OR; end
        OP_XOR:   begin ctl.accWe = 1'b1; ctl.aluOp = ALU_XOR; end
        OP_SHL:   begin ctl.accWe = 1'b1; ctl.ovWe = 1'b1; ctl.aluOp = ALU_SHL; end
        OP_LOAD:  begin ctl.accWe = 1'b1; ctl.accFromMem = 1'b1; end
        OP_STORE: ctl.memWe = 1'b1;
        OP_BEQ:   ctl.pcLoad = accEqOp;
        OP_BNE:   ctl.pcLoad = !accEqOp;
        OP_JMP:   ctl.pcLoad = 1'b1;
        default:  ;
      endcase
      ctl.pcStep = !ctl.pcLoad && (opcode != OP_STOP);
    end
  end

  assign done = doneQ;

  AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !start && opcode == OP_STOP) |=> (doneQ && !runQ)); // R9
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IADDR_W = 6,
  parameter int NREG    = 32,
  parameter int NMEM    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctl,
  input  logic               romWe,
  input  logic [IADDR_W-1:0] romAddr,
  input  logic [INS_W-1:0]   romData,
  input  logic               tblWe,
  input  logic [FLD_W-1:0]   tblAddr,
  input  logic [IADDR_W-1:0] tblData,
  input  logic [FLD_W-1:0]   dbgRegSel,
  input  logic [FLD_W-1:0]   dbgMemSel,
  output opcode_e            opcode,
  output logic               accEqOp,
  output logic [IADDR_W-1:0] pc,
  output logic [DATA_W-1:0]  dbgRegVal,
  output logic [DATA_W-1:0]  dbgMemVal
);
  localparam int ROM_D  = 1 << IADDR_W;
  localparam int TBL_D  = 1 << FLD_W;
  localparam int REG_AW = $clog2(NREG);
  localparam int MEM_AW = $clog2(NMEM);

  logic [INS_W-1:0]   rom [ROM_D];
  logic [IADDR_W-1:0] tbl [TBL_D];
  logic [DATA_W-1:0]  rf  [NREG];
  logic [DATA_W-1:0]  dm  [NMEM];
  logic [IADDR_W-1:0] pcQ;

  logic [INS_W-1:0]   instr;
  logic [FLD_W-1:0]   fld;
  logic [DATA_W-1:0]  accVal, opVal, memRd, aluRes, accNext, ovWord;
  logic [MEM_AW-1:0]  memAddr;
  logic [IADDR_W-1:0] tgtVal;
  logic               aluOv;

  // program storage, written from outside before a run
  always_ff @(posedge clk) begin
    if (romWe) rom[romAddr] <= romData;
    if (tblWe) tbl[tblAddr] <= tblData;
  end

  assign instr   = rom[pcQ];
  assign opcode  = opcode_e'(instr[INS_W-1:FLD_W]);
  assign fld     = instr[FLD_W-1:0];
  assign accVal  = rf[0];
  assign opVal   = rf[REG_AW'(fld)];
  assign accEqOp = (accVal == opVal);
  assign memAddr = opVal[MEM_AW-1:0];
  assign memRd   = dm[memAddr];
  assign tgtVal  = tbl[fld];

  acc_alu #(.DATA_W(DATA_W)) uAlu (
    .op    (ctl.aluOp),
    .accIn (accVal),
    .opIn  (opVal),
    .immIn (fld),
    .res   (aluRes),
    .ovBit (aluOv)
  );

  assign accNext = ctl.accFromMem ? memRd : aluRes;
  assign ovWord  = {{(DATA_W-1){1'b0}}, aluOv};

  // per-entry write selects for the register file
  logic [NREG-1:0]   rfWe;
  logic [DATA_W-1:0] rfWd [NREG];
  for (genvar g = 0; g < NREG; g++) begin : gRegSel
    assign rfWe[g] = (g == 0 && ctl.accWe) || (g == 1 && ctl.ovWe) ||
                     (ctl.regWe && REG_AW'(fld) == REG_AW'(g));
    assign rfWd[g] = (g == 0 && ctl.accWe) ? accNext :
                     (g == 1 && ctl.ovWe)  ? ovWord  : accVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) if (rfWe[i]) rf[i] <= rfWd[i];
    end
  end

  // per-word write selects for data memory
  logic [NMEM-1:0] dmWe;
  for (genvar g = 0; g < NMEM; g++) begin : gMemSel
    assign dmWe[g] = ctl.memWe && (memAddr == MEM_AW'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NMEM; i++) dm[i] <= '0;
    end else begin
      for (int i = 0; i < NMEM; i++) if (dmWe[i]) dm[i] <= accVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pcQ <= '0;
    else if (ctl.pcClear) pcQ <= '0;
    else if (ctl.pcLoad)  pcQ <= tgtVal;
    else if (ctl.pcStep)  pcQ <= pcQ + 1'b1;
  end

  assign pc        = pcQ;
  assign dbgRegVal = rf[REG_AW'(dbgRegSel)];
  assign dbgMemVal = dm[MEM_AW'(dbgMemSel)];

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ovWe && ctl.aluOp == ALU_ADD) |=>
      ({rf[1], rf[0]} == $past({{(DATA_W-1){1'b0}}, ({1'b0, accVal} + {1'b0, opVal})}))); // R2
  AST_STORE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWe |=> (dm[$past(memAddr)] == $past(accVal))); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcStep |=> (pcQ == IADDR_W'($past(pcQ) + IADDR_W'(1)))); // R6
  AST_TABLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcLoad && !tblWe) |=> (pcQ == $past(tgtVal))); // R7
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IADDR_W = 6,
  parameter int NREG    = 32,
  parameter int NMEM    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               romWe,
  input  logic [IADDR_W-1:0] romAddr,
  input  logic [8:0]         romData,
  input  logic               tblWe,
  input  logic [4:0]         tblAddr,
  input  logic [IADDR_W-1:0] tblData,
  input  logic [4:0]         dbgRegSel,
  input  logic [4:0]         dbgMemSel,
  output logic [IADDR_W-1:0] pc,
  output logic               done,
  output logic [DATA_W-1:0]  dbgRegVal,
  output logic [DATA_W-1:0]  dbgMemVal
);
  ctrl_t   ctl;
  opcode_e opcode;
  logic    accEqOp;

  acc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .accEqOp (accEqOp),
    .ctl     (ctl),
    .done    (done)
  );

  acc_dpath #(
    .DATA_W (DATA_W),
    .IADDR_W(IADDR_W),
    .NREG   (NREG),
    .NMEM   (NMEM)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .romWe    (romWe),
    .romAddr  (romAddr),
    .romData  (romData),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblData  (tblData),
    .dbgRegSel(dbgRegSel),
    .dbgMemSel(dbgMemSel),
    .opcode   (opcode),
    .accEqOp  (accEqOp),
    .pc       (pc),
    .dbgRegVal(dbgRegVal),
    .dbgMemVal(dbgMemVal)
  );

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(pc) && done)); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (pc == '0 && !done)); // R10
endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  localparam int IW = 6;
  localparam int ROMN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic romWe = 1'b0;
  logic [IW-1:0] romAddr = '0;
  logic [8:0] romData = '0;
  logic tblWe = 1'b0;
  logic [4:0] tblAddr = '0;
  logic [IW-1:0] tblData = '0;
  logic [4:0] dbgRegSel = '0;
  logic [4:0] dbgMemSel = '0;
  logic [IW-1:0] pc;
  logic done;
  logic [7:0] dbgRegVal, dbgMemVal;

  acc_core u0 (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // bench-side program image and reference state
  logic [8:0] bRom [ROMN];
  logic [IW-1:0] bLut [32];
  int mRf [32];
  int mDm [32];
  int mPc;
  bit mRun, mDone;

  function automatic logic [8:0] enc(int op, int f);
    return {op[3:0], f[4:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (pc=%0d)", req, act, exp, mPc);
    end
  endtask

  function automatic void modelStep(bit st);
    int op, f, a, b, s, nxt;
    if (st) begin mPc = 0; mRun = 1; mDone = 0; return; end
    if (!mRun) return;
    op = int'(bRom[mPc][8:5]); f = int'(bRom[mPc][4:0]);
    a = mRf[0]; b = mRf[f]; nxt = (mPc + 1) % ROMN;
    case (op)
      1: mRf[f] = a;
      2: mRf[0] = b;
      3: mRf[0] = f;
      4: begin s = a + b; mRf[0] = s % 256; mRf[1] = s / 256; end
      5: begin mRf[0] = (a - b) & 255; mRf[1] = (a < b) ? 1 : 0; end
      6: mRf[0] = a & b;
      7: mRf[0] = a | b;
      8: mRf[0] = a ^ b;
      9: begin mRf[0] = (a * 2) & 255; mRf[1] = a / 128; end
      10: mRf[0] = mDm[b % 32];
      11: mDm[b % 32] = a;
      12: if (a == b) nxt = int'(bLut[f]);
      13: if (a != b) nxt = int'(bLut[f]);
      14: nxt = int'(bLut[f]);
      15: begin mRun = 0; mDone = 1; nxt = mPc; end
      default: ;
    endcase
    mPc = nxt;
  endfunction

  // one clock: drive at negedge, step reference, compare at next negedge
  task automatic tick(bit st);
    string tp, ta;
    int op;
    tp = "R6"; ta = "R1";
    if (st) begin tp = "R10"; ta = "R10"; end
    else if (mRun) begin
      op = int'(bRom[mPc][8:5]);
      if (op == 12 || op == 13) tp = "R7";
      else if (op == 14) tp = "R8";
      else if (op == 15) tp = "R9";
      if (op == 4) ta = "R2";
      else if (op >= 5 && op <= 9) ta = "R3";
      else if (op >= 1 && op <= 3) ta = "R4";
      else if (op == 10 || op == 11) ta = "R5";
    end else begin
      tp = "R9"; ta = "R9";
    end
    start = st;
    modelStep(st);
    @(negedge clk);
    start = 1'b0;
    chk(tp, int'(pc), mPc);
    chk("R9", int'(done), int'(mDone));
    chk(ta, int'(dbgRegVal), mRf[0]);
  endtask

  task automatic dumpAll(string regTag, string memTag);
    for (int i = 0; i < 32; i++) begin
      dbgRegSel = 5'(i); dbgMemSel = 5'(i);
      #0.1;
      chk(regTag, int'(dbgRegVal), mRf[i]);
      chk(memTag, int'(dbgMemVal), mDm[i]);
    end
    dbgRegSel = '0; dbgMemSel = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    for (int i = 0; i < 32; i++) begin mRf[i] = 0; mDm[i] = 0; end
    mPc = 0; mRun = 0; mDone = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    chk("R10", int'(pc), 0);
    chk("R10", int'(done), 0);
    dumpAll("R10", "R10");
    tick(0);
  endtask

  task automatic clearImage();
    for (int i = 0; i < ROMN; i++) bRom[i] = 9'd0;
    for (int i = 0; i < 32; i++) bLut[i] = '0;
  endtask

  // R11: write the image through the load ports
  task automatic loadImage();
    for (int i = 0; i < ROMN; i++) begin
      romWe = 1'b1; romAddr = IW'(i); romData = bRom[i];
      tblWe = (i < 32); tblAddr = 5'(i); tblData = bLut[i % 32];
      tick(0);
    end
    romWe = 1'b0; tblWe = 1'b0;
  endtask

  task automatic runProgram(string regTag);
    int n;
    tick(1);
    n = 0;
    while (mRun && n < 400) begin tick(0); n++; end
    chk("R9", int'(done), 1);
    repeat (4) tick(0);
    dumpAll(regTag, "R5");
    tick(1);
    chk("R10", int'(pc), 0);
    chk("R10", int'(done), 0);
    n = 0;
    while (mRun && n < 400) begin tick(0); n++; end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // program A: arithmetic, moves, carry/borrow into register 1
    clearImage();
    bRom[0]  = enc(3, 31); bRom[1]  = enc(1, 2);  bRom[2]  = enc(4, 2);
    bRom[3]  = enc(4, 0);  bRom[4]  = enc(4, 0);  bRom[5]  = enc(4, 2);
    bRom[6]  = enc(1, 3);  bRom[7]  = enc(3, 5);  bRom[8]  = enc(5, 3);
    bRom[9]  = enc(1, 4);  bRom[10] = enc(8, 2);  bRom[11] = enc(9, 0);
    bRom[12] = enc(7, 3);  bRom[13] = enc(6, 4);  bRom[14] = enc(2, 1);
    bRom[15] = enc(1, 5);  bRom[16] = enc(3, 30); bRom[17] = enc(5, 5);
    bRom[18] = enc(4, 1);  bRom[19] = enc(15, 0);
    loadImage();
    runProgram("R4");

    // program B: indirect memory, loop with BNE, BEQ taken and not, JMP
    doReset();
    clearImage();
    bRom[0]  = enc(3, 1);  bRom[1]  = enc(1, 6);  bRom[2]  = enc(3, 14);
    bRom[3]  = enc(1, 5);  bRom[4]  = enc(3, 10); bRom[5]  = enc(1, 4);
    bRom[6]  = enc(2, 4);  bRom[7]  = enc(11, 4); bRom[8]  = enc(4, 6);
    bRom[9]  = enc(1, 4);  bRom[10] = enc(13, 5);
    bRom[11] = enc(3, 12); bRom[12] = enc(1, 7);  bRom[13] = enc(10, 7);
    bRom[14] = enc(12, 7); bRom[15] = enc(3, 1);  bRom[16] = enc(15, 0);
    bRom[17] = enc(3, 20); bRom[18] = enc(4, 0);  bRom[19] = enc(1, 8);
    bRom[20] = enc(3, 9);  bRom[21] = enc(11, 8); bRom[22] = enc(10, 8);
    bRom[23] = enc(12, 6); bRom[24] = enc(13, 8); bRom[25] = enc(3, 2);
    bRom[26] = enc(15, 0); bRom[27] = enc(14, 9); bRom[28] = enc(3, 3);
    bRom[29] = enc(15, 0); bRom[30] = enc(3, 17); bRom[31] = enc(1, 9);
    bRom[32] = enc(15, 0);
    bLut[5] = 6'd6; bLut[6] = 6'd0; bLut[7] = 6'd17; bLut[8] = 6'd27; bLut[9] = 6'd30;
    loadImage();
    runProgram("R11");
    chk("R5", mDm[8], 9);

    // program C: PC runs off the end of the ROM and wraps to 0
    doReset();
    clearImage();
    bRom[0]  = enc(2, 9);  bRom[1]  = enc(13, 10); bRom[2] = enc(14, 11);
    bRom[3]  = enc(15, 0); bRom[61] = enc(3, 7);   bRom[62] = enc(1, 9);
    bLut[10] = 6'd3; bLut[11] = 6'd61;
    loadImage();
    runProgram("R6");
    chk("R6", mRf[9], 7);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule